// File: doc/BRIEF.md
# Reloadable Divide-by-N Timer

This block is an 8-bit down-counter that divides a selected count source by n+1, where n is the value held in its reload latch. When the counter steps below zero it takes the latch value again. It also drives a one-cycle underflow pulse and sets a sticky interrupt-request flag. The count source is either an internal clock enable or an external enable. Because the underflow pulse has the same form as an enable, one timer can drive the external enable of a second timer, and the two then form a chain.

Software reaches the block through a simple register port with a write strobe, an address, write data and combinational read data. A write-mode bit in the control register decides what a value write does. In one mode it updates only the reload latch. In the other it updates the latch and the live counter together. The latch-only mode holds even while the timer is stopped, so the counter keeps its old contents until the next reload. The source selection is locked while the timer runs.

Top module: `rtmr_timer`

## Requirements
- R1: After reset, address 0 (live counter) and address 2 (reload latch) both read 0xFF, address 1 (control) reads 0, and `uf_pulse` and `irq` are low.
- R2: With latch value n and the timer running on a tick every cycle, `uf_pulse` is high in exactly floor(k/(n+1)) of the k cycles that follow the edge which starts the timer, for n from 0 to 255.
- R3: With control bit 1 (write mode) at 1, a write to address 0 changes only the latch. The counter read at address 0 is unchanged when the timer is stopped, and it keeps decrementing normally when the timer is running.
- R4: With control bit 1 at 0, a write to address 0 loads the latch and the counter on the same edge. If a tick arrives on that edge, the write takes precedence and no count happens.
- R5: On underflow the counter takes the latch value it held before that edge. The read at address 0 in the cycle of the pulse shows that value.
- R6: The interrupt flag (control bit 3) is set on every underflow. A control write with bit 3 at 0 clears it, and a control write with bit 3 at 1 leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R7: Control bit 2 selects the source: 0 is `tick_int` and 1 is the external enable. A control write made while bit 0 (run) is 1 leaves bit 2 unchanged. A control write made while the timer is stopped updates it.
- R8: With bit 2 at 1 the counter advances only on `tick_ext` and ignores `tick_int`. When the `uf_pulse` of a first timer drives the `tick_ext` of a second timer, the second timer underflows once per (m+1) pulses of the first, where m is the second timer's latch value.
- R9: While control bit 0 is 0, the counter does not change except by a register write, and `uf_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address: 0 value, 1 control, 2 latch readback |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| tick_int | input | 1 | Internal count enable |
| tick_ext | input | 1 | External count enable, or the underflow of another timer |
| uf_pulse | output | 1 | One-cycle pulse after each underflow |
| irq | output | 1 | Sticky interrupt-request flag |

## Verification
The bench builds two instances with the default parameters: WIDTH of 8, a reset value of all ones, and the external enable used as a level. The second instance takes the first one's underflow pulse as its external enable, which brings the chained division and the one-cycle lag per stage within reach. Because the width is 8, the table can sweep latch values from 0 (divide by one, a pulse every cycle) up to 255 (the full range) within a short run. The level-mode external enable lets the bench step the counter one pulse at a time.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
   // register addresses
   localparam int ADDR_VALUE = 0;
   localparam int ADDR_CTRL  = 1;
   localparam int ADDR_LATCH = 2;

   // control field bit positions
   localparam int BIT_RUN   = 0;
   localparam int BIT_WMODE = 1;
   localparam int BIT_SRC   = 2;
   localparam int BIT_IRQ   = 3;
   localparam int CTRL_BITS = 4;

   typedef struct packed {
      logic irq;
      logic src;
      logic wmode;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/rtmr_edge.sv
`timescale 1ns/1ps
// Rising-edge detector for an external enable that is a level, not a pulse.
module rtmr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic rise_out
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_in;
   end

   assign rise_out = lvl_in & ~lvl_q;
endmodule

// File: rtl/rtmr_core.sv
`timescale 1ns/1ps
// Reload latch, down-counter and underflow generation.
module rtmr_core #(
   parameter int              WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             cnt_load,
   input  logic             latch_load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] cnt,
   output logic [WIDTH-1:0] latch,
   output logic             uf_evt,
   output logic             uf_pulse
);
   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

   logic step;

   // a load from the bus wins over a tick on the same edge
   assign step   = run & tick & ~cnt_load;
   assign uf_evt = step & (cnt == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= RESET_VAL;
      end else if (latch_load) begin
         latch <= load_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= RESET_VAL;
      end else if (cnt_load) begin
         cnt <= load_val;
      end else if (step) begin
         cnt <= uf_evt ? latch : (cnt - ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) uf_pulse <= 1'b0;
      else        uf_pulse <= uf_evt;
   end
endmodule

// File: rtl/rtmr_regs.sv
`timescale 1ns/1ps
// Register decode, control state and read multiplexer.
module rtmr_regs
   import rtmr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic              uf_evt,
   input  logic [WIDTH-1:0]  cnt,
   input  logic [WIDTH-1:0]  latch,
   output ctrl_t             ctrl,
   output logic              cnt_load,
   output logic              latch_load,
   output logic [WIDTH-1:0]  bus_rdata
);
   localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(ADDR_VALUE);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(ADDR_LATCH);

   logic value_wr;
   logic ctrl_wr;

   assign value_wr   = bus_wr & (bus_addr == A_VALUE);
   assign ctrl_wr    = bus_wr & (bus_addr == A_CTRL);
   assign latch_load = value_wr;
   assign cnt_load   = value_wr & ~ctrl.wmode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl.run   <= 1'b0;
         ctrl.wmode <= 1'b0;
         ctrl.src   <= 1'b0;
      end else if (ctrl_wr) begin
         ctrl.run   <= bus_wdata[BIT_RUN];
         ctrl.wmode <= bus_wdata[BIT_WMODE];
         // source is frozen while the timer runs
         if (!ctrl.run) ctrl.src <= bus_wdata[BIT_SRC];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl.irq <= 1'b0;
      end else if (uf_evt) begin
         ctrl.irq <= 1'b1;
      end else if (ctrl_wr && !bus_wdata[BIT_IRQ]) begin
         ctrl.irq <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_VALUE: bus_rdata = cnt;
         A_CTRL:  bus_rdata = WIDTH'(ctrl);
         A_LATCH: bus_rdata = latch;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rtmr_timer.sv
`timescale 1ns/1ps
// Reloadable divide-by-(n+1) timer, top level.
module rtmr_timer
   import rtmr_pkg::*;
#(
   parameter int               WIDTH     = 8,
   parameter int               ADDR_W    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1,
   parameter bit               EXT_EDGE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              tick_int,
   input  logic              tick_ext,
   output logic              uf_pulse,
   output logic              irq
);
   // elaboration-time parameter checks
   if (WIDTH < CTRL_BITS) begin : g_bad_width
      $error("rtmr_timer: WIDTH must hold the control field");
   end
   if ((1 << ADDR_W) <= ADDR_LATCH) begin : g_bad_addr
      $error("rtmr_timer: ADDR_W too small for the register map");
   end

   ctrl_t            ctrl_q;
   logic             run_q, wmode_q, src_q, irq_q;
   logic [WIDTH-1:0] cnt_q, latch_q;
   logic             cnt_load, latch_load, uf_evt;
   logic             ext_tick, tick_sel;

   assign run_q   = ctrl_q.run;
   assign wmode_q = ctrl_q.wmode;
   assign src_q   = ctrl_q.src;
   assign irq_q   = ctrl_q.irq;

   // external enable: pulse as-is, or level converted to rising edges
   if (EXT_EDGE) begin : g_ext_edge
      rtmr_edge u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_in   (tick_ext),
         .rise_out (ext_tick)
      );
   end else begin : g_ext_pulse
      assign ext_tick = tick_ext;
   end

   assign tick_sel = src_q ? ext_tick : tick_int;

   rtmr_regs #(
      .WIDTH  (WIDTH),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .uf_evt     (uf_evt),
      .cnt        (cnt_q),
      .latch      (latch_q),
      .ctrl       (ctrl_q),
      .cnt_load   (cnt_load),
      .latch_load (latch_load),
      .bus_rdata  (bus_rdata)
   );

   rtmr_core #(
      .WIDTH     (WIDTH),
      .RESET_VAL (RESET_VAL)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .tick       (tick_sel),
      .cnt_load   (cnt_load),
      .latch_load (latch_load),
      .load_val   (bus_wdata),
      .cnt        (cnt_q),
      .latch      (latch_q),
      .uf_evt     (uf_evt),
      .uf_pulse   (uf_pulse)
   );

   assign irq = irq_q;
endmodule

// File: rtl/rtmr_timer_chk.sv
`timescale 1ns/1ps
// Property checker, bound to every rtmr_timer instance.
module rtmr_timer_chk
   import rtmr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic              run,
   input logic              wmode,
   input logic              src,
   input logic              irq,
   input logic [WIDTH-1:0]  cnt,
   input logic [WIDTH-1:0]  latch,
   input logic              uf_pulse
);
   logic value_wr, ctrl_wr;
   assign value_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_VALUE));
   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));

   assert_load_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(value_wr && !wmode) |-> (cnt == $past(bus_wdata) && latch == $past(bus_wdata)));

   assert_latch_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(value_wr && wmode && !run) |-> ($stable(cnt) && latch == $past(bus_wdata)));

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      uf_pulse |-> (cnt == $past(latch)));

   assert_uf_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      uf_pulse |-> irq);

   assert_irq_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && !irq) |-> $past(ctrl_wr && !bus_wdata[BIT_IRQ]));

   assert_src_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(src));

   assert_stopped_no_uf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !uf_pulse);

   assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run && !value_wr) |-> $stable(cnt));
endmodule

bind rtmr_timer rtmr_timer_chk #(
   .WIDTH  (WIDTH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .run       (run_q),
   .wmode     (wmode_q),
   .src       (src_q),
   .irq       (irq_q),
   .cnt       (cnt_q),
   .latch     (latch_q),
   .uf_pulse  (uf_pulse)
);

// File: tb/sim_rtmr_timer.sv
`timescale 1ns/1ps
module sim_rtmr_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr0 = 1'b0, wr1 = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] rdata0, rdata1;
   logic       tick_int = 1'b0, tick_ext = 1'b0;
   logic       uf0, uf1, irq0, irq1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rtmr_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr0), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata0), .tick_int(tick_int),
      .tick_ext(tick_ext), .uf_pulse(uf0), .irq(irq0)
   );

   // second stage counts the first stage's underflows
   rtmr_timer u1 (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr1), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata1), .tick_int(1'b0),
      .tick_ext(uf0), .uf_pulse(uf1), .irq(irq1)
   );

   // latch n, counted cycles T, expected pulses, counter after stop, irq
   localparam int VEC [0:6][0:4] = '{
      '{  0,   5, 5,   0, 1},
      '{  1,   6, 3,   0, 1},
      '{  3,  10, 2,   0, 1},
      '{  4,  12, 2,   1, 1},
      '{  9,  25, 2,   3, 1},
      '{255, 300, 1, 210, 1},
      '{  7,   5, 0,   1, 0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr_reg(input int which, input int a, input int d);
      bus_addr  = 2'(a);
      bus_wdata = 8'(d);
      if (which == 0) wr0 = 1'b1; else wr1 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr0 = 1'b0;
      wr1 = 1'b0;
   endtask

   task automatic rd0(input int a, output int v);
      bus_addr = 2'(a);
      #1;
      v = int'(rdata0);
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int v, n_uf, n_uf1, c;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd0(0, v); chk("R1 counter", v, 255);
      rd0(2, v); chk("R1 latch", v, 255);
      rd0(1, v); chk("R1 control", v, 0);
      chk("R1 uf_pulse", int'(uf0), 0);
      chk("R1 irq", int'(irq0), 0);

      // R2/R4/R5 table of division ratios, internal tick every cycle
      tick_int = 1'b1;
      for (int i = 0; i < 7; i++) begin
         wr_reg(0, 1, 8'h00);
         wr_reg(0, 0, VEC[i][0]);
         rd0(0, v); chk("R4 counter after load", v, VEC[i][0]);
         rd0(2, v); chk("R4 latch after load", v, VEC[i][0]);
         wr_reg(0, 1, 8'h01);
         n_uf = 0;
         for (int k = 0; k < VEC[i][1]; k++) begin
            cyc();
            if (uf0) n_uf++;
         end
         wr_reg(0, 1, 8'h08);
         chk("R2 underflow count", n_uf, VEC[i][2]);
         rd0(0, v); chk("R5 counter after stop", v, VEC[i][3]);
         chk("R6 irq after run", int'(irq0), VEC[i][4]);
      end

      // R3 latch-only write while stopped, then R5 reload uses the new latch
      wr_reg(0, 1, 8'h00);
      wr_reg(0, 0, 2);
      wr_reg(0, 1, 8'h02);
      wr_reg(0, 0, 5);
      rd0(0, v); chk("R3 stopped counter kept", v, 2);
      rd0(2, v); chk("R3 stopped latch updated", v, 5);
      wr_reg(0, 1, 8'h03);
      bus_addr = 2'd0;
      cyc(); #1; chk("R2 step 1 counter", int'(rdata0), 1); chk("R2 step 1 no pulse", int'(uf0), 0);
      cyc(); #1; chk("R2 step 2 counter", int'(rdata0), 0); chk("R2 step 2 no pulse", int'(uf0), 0);
      cyc(); #1; chk("R5 reload value", int'(rdata0), 5); chk("R2 pulse on underflow", int'(uf0), 1);
      // R3 latch-only write while running: counter keeps stepping
      wr_reg(0, 0, 8'h30);
      rd0(0, v); chk("R3 running counter steps", v, 4);
      rd0(2, v); chk("R3 running latch updated", v, 48);
      wr_reg(0, 1, 8'h0A);
      rd0(0, v); chk("R3 counter after stop", v, 3);

      // R4 a load on a ticking edge wins over the count
      wr_reg(0, 1, 8'h01);
      wr_reg(0, 0, 9);
      rd0(0, v); chk("R4 load beats tick", v, 9);
      wr_reg(0, 1, 8'h08);

      // R7 source lock while running
      wr_reg(0, 1, 8'h01);
      wr_reg(0, 1, 8'h05);
      rd0(1, v); chk("R7 source held while running", (v >> 2) & 1, 0);
      wr_reg(0, 1, 8'h08);
      wr_reg(0, 1, 8'h0C);
      rd0(1, v); chk("R7 source set while stopped", (v >> 2) & 1, 1);

      // R8 external source: ignores tick_int, counts tick_ext
      wr_reg(0, 1, 8'h04);
      wr_reg(0, 0, 2);
      wr_reg(0, 1, 8'h05);
      repeat (4) cyc();
      rd0(0, v); chk("R8 tick_int ignored", v, 2);
      bus_addr = 2'd0;
      tick_ext = 1'b1; cyc(); tick_ext = 1'b0; #1;
      chk("R8 ext tick 1", int'(rdata0), 1);
      tick_ext = 1'b1; cyc(); tick_ext = 1'b0; #1;
      chk("R8 ext tick 2", int'(rdata0), 0);
      tick_ext = 1'b1; cyc(); tick_ext = 1'b0; #1;
      chk("R8 ext underflow reload", int'(rdata0), 2);
      chk("R8 ext underflow pulse", int'(uf0), 1);

      // R6 flag write semantics
      wr_reg(0, 1, 8'h0C);
      chk("R6 irq kept by bit3=1", int'(irq0), 1);
      wr_reg(0, 1, 8'h08);
      chk("R6 irq kept again", int'(irq0), 1);
      wr_reg(0, 1, 8'h00);
      chk("R6 irq cleared by bit3=0", int'(irq0), 0);

      // R9 stopped timer ignores ticks
      rd0(0, c);
      n_uf = 0;
      tick_ext = 1'b1;
      for (int k = 0; k < 5; k++) begin
         cyc();
         if (uf0) n_uf++;
      end
      tick_ext = 1'b0;
      rd0(0, v); chk("R9 counter held while stopped", v, c);
      chk("R9 no pulse while stopped", n_uf, 0);

      // R8 cascade: u1 counts u0 underflows
      wr_reg(1, 1, 8'h04);
      wr_reg(1, 0, 1);
      wr_reg(1, 1, 8'h05);
      wr_reg(0, 1, 8'h00);
      wr_reg(0, 0, 2);
      wr_reg(0, 1, 8'h01);
      n_uf = 0; n_uf1 = 0;
      for (int k = 0; k < 32; k++) begin
         cyc();
         if (uf0) n_uf++;
         if (uf1) n_uf1++;
      end
      chk("R8 first stage pulses", n_uf, 10);
      chk("R8 second stage pulses", n_uf1, 5);
      chk("R6 second stage irq", int'(irq1), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule